// File: doc/BRIEF.md
# Card-Detect Gated Power Control

This block drives three power switch enables for a hot-swap slot from a small configuration register that software writes and reads. An optional gating mode ties those enables to two card-detect inputs. While gating is on, software can turn power on only when both detect lines are low, meaning a card is seated. If either line rises, every enable drops on its own, with no software action. While gating is off, the enables simply follow what software last wrote.

The detect inputs carry the value seen at general-purpose pins. When firmware drives those pins as outputs, the pin value equals the driven value. Software can therefore fake an insertion or a removal to test the hot-swap path. The detect lines pass through a synchronizer before use.

A strap input reports that the slot is owned by a dedicated slot controller. While the strap is set, this register has no control: the enables and the gating bit stay at zero.

Top module: `pgc_top`

## Requirements
- R1: After a synchronous reset, `pwr_out` is 0, the gating bit is 0, and `rdata` is 0.
- R2: With gating off (write data bit 3 = 0), a write to the configuration address sets `pwr_out` to write data bits [2:0] on the next clock edge, whatever the detect lines are.
- R3: With gating on (write data bit 3 = 1) and both synchronized detect lines low, a write sets `pwr_out` to write data bits [2:0] on the next edge.
- R4: With gating on, a write made while a synchronized detect line is high leaves `pwr_out` at 0. This holds even when that same write is the one that turns gating on.
- R5: With gating on, `pwr_out` falls to 0 on the third clock edge after a detect pin rises. It stays 0 after the pin falls again, until software writes it.
- R6: A change on a detect pin has no effect on `pwr_out` over the first two clock edges after it, because of the two-stage synchronizer.
- R7: While `slot_mode` is high, `pwr_out` and the gating bit stay 0 and writes have no effect.
- R8: A read of the configuration address returns, one edge after `rd_en`, the power bits in [2:0], the gating bit in [3] and the synchronized detect lines in [9:8]. A read of any other address returns 0. `rdata` holds its value when `rd_en` is low.
- R9: A write to any address other than the configuration address (default 0) leaves `pwr_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_mode | input | 1 | Strap: slot controller owns the outputs, register control disabled |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | N_PWR+1 | Write data: power bits [2:0], gating bit [3] |
| rdata | output | 8+N_DET | Registered read data |
| det_pin | input | N_DET | Card-detect pin levels, high means card absent |
| pwr_out | output | N_PWR | Registered power switch enables |

## Verification
A wrong gating or clear state shows up at `pwr_out` as enables that stay on after a removal. In that case the output is still high on the third edge after the detect pin rises. A wrong state can also show as enables that turn on from a write made with a detect line high, which appears one edge after the write. A synchronizer with the wrong depth moves the clear one edge earlier or later, so `pwr_out` is sampled on the second and the third edge after the pin change. A wrong stored gating bit or detect value appears in `rdata` one edge after a read.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int DEF_PWR_N  = 3;
  localparam int DEF_DET_N  = 2;
  localparam int DET_OFS    = 8;
  localparam int DEF_STAGES = 2;

  function automatic int rd_width(input int det_n);
    return DET_OFS + det_n;
  endfunction
endpackage

// File: rtl/pgc_det_sync.sv
module pgc_det_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pgc_pwr_reg.sv
module pgc_pwr_reg #(
  parameter int N_PWR = 3,
  parameter int N_DET = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_mode,
  input  logic             wr_hit,
  input  logic [N_PWR-1:0] wr_pwr,
  input  logic             wr_gate,
  input  logic [N_DET-1:0] det_s,
  output logic [N_PWR-1:0] pwr_q,
  output logic             gate_q
);
  logic [N_PWR-1:0] pwr_n;
  logic             gate_n;

  always_comb begin
    pwr_n  = wr_hit ? wr_pwr  : pwr_q;
    gate_n = wr_hit ? wr_gate : gate_q;
    if (gate_n && (|det_s)) pwr_n = '0;
    if (slot_mode) begin
      pwr_n  = '0;
      gate_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      pwr_q  <= pwr_n;
      gate_q <= gate_n;
    end
  end
endmodule

// File: rtl/pgc_rd_port.sv
module pgc_rd_port
  import pgc_pkg::*;
#(
  parameter int N_PWR = 3,
  parameter int N_DET = 2,
  parameter int RD_W  = DET_OFS + N_DET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             rd_hit,
  input  logic [N_PWR-1:0] pwr_q,
  input  logic             gate_q,
  input  logic [N_DET-1:0] det_s,
  output logic [RD_W-1:0]  rdata
);
  logic [RD_W-1:0] img;

  always_comb begin
    img                    = '0;
    img[N_PWR-1:0]         = pwr_q;
    img[N_PWR]             = gate_q;
    img[DET_OFS +: N_DET]  = det_s;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_hit ? img : '0;
  end
endmodule

// File: rtl/pgc_top.sv
module pgc_top
  import pgc_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = '0,
  parameter int                N_PWR       = DEF_PWR_N,
  parameter int                N_DET       = DEF_DET_N,
  parameter int                SYNC_STAGES = DEF_STAGES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slot_mode,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [N_PWR:0]           wdata,
  output logic [DET_OFS+N_DET-1:0] rdata,
  input  logic [N_DET-1:0]         det_pin,
  output logic [N_PWR-1:0]         pwr_out
);
  localparam int RD_W = rd_width(N_DET);

  logic [N_DET-1:0] det_s;
  logic             gate_q;
  logic             hit;

  assign hit = (addr == CFG_ADDR);

  pgc_det_sync #(.W(N_DET), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (det_pin),
    .q   (det_s)
  );

  pgc_pwr_reg #(.N_PWR(N_PWR), .N_DET(N_DET)) u_pwr (
    .clk       (clk),
    .rst       (rst),
    .slot_mode (slot_mode),
    .wr_hit    (wr_en && hit),
    .wr_pwr    (wdata[N_PWR-1:0]),
    .wr_gate   (wdata[N_PWR]),
    .det_s     (det_s),
    .pwr_q     (pwr_out),
    .gate_q    (gate_q)
  );

  pgc_rd_port #(.N_PWR(N_PWR), .N_DET(N_DET), .RD_W(RD_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_hit (hit),
    .pwr_q  (pwr_out),
    .gate_q (gate_q),
    .det_s  (det_s),
    .rdata  (rdata)
  );
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk #(
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR = '0,
  parameter int                N_PWR    = 3,
  parameter int                N_DET    = 2,
  parameter int                RD_W     = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_PWR:0]    wdata,
  input logic [RD_W-1:0]   rdata,
  input logic [N_DET-1:0]  det_s,
  input logic              gate_q,
  input logic [N_PWR-1:0]  pwr_out
);
  logic wr_hit;
  assign wr_hit = wr_en && (addr == CFG_ADDR);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pwr_out == '0 && rdata == '0)); // R1
  AST_UNGATED_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wdata[N_PWR] && !slot_mode) |=> pwr_out == $past(wdata[N_PWR-1:0])); // R2
  AST_GATED_SET_SEATED: assert property (@(posedge clk) disable iff (rst)
    (gate_q && pwr_out != '0) |-> $past(det_s) == '0); // R3
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wdata[N_PWR] && (|det_s)) |=> pwr_out == '0); // R4
  AST_REMOVAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (gate_q && (|det_s) && !wr_hit) |=> pwr_out == '0); // R5
  AST_SLOT_MODE_OFF: assert property (@(posedge clk) disable iff (rst)
    slot_mode |=> (pwr_out == '0 && !gate_q)); // R7
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R8
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != CFG_ADDR && !slot_mode && !(gate_q && (|det_s))) |=> $stable(pwr_out)); // R9
endmodule

bind pgc_top pgc_chk #(
  .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .N_PWR(N_PWR), .N_DET(N_DET), .RD_W(RD_W)
) u_chk (
  .clk(clk), .rst(rst), .slot_mode(slot_mode), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .det_s(det_s), .gate_q(gate_q),
  .pwr_out(pwr_out)
);

// File: tb/sim_pgc_top.sv
`timescale 1ns/1ps
module sim_pgc_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [9:0] rdata;
  logic [1:0] det_pin = '0;
  logic [2:0] pwr_out;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pgc_top u0 (
    .clk(clk), .rst(rst), .slot_mode(slot_mode), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .det_pin(det_pin), .pwr_out(pwr_out)
  );

  // fields: [8:7] detect pins, [6] gating, [5:3] power written, [2:0] expected
  localparam logic [8:0] VEC [8] = '{
    {2'b00, 1'b0, 3'b101, 3'b101},
    {2'b11, 1'b0, 3'b011, 3'b011},
    {2'b00, 1'b1, 3'b111, 3'b111},
    {2'b01, 1'b1, 3'b110, 3'b000},
    {2'b10, 1'b1, 3'b001, 3'b000},
    {2'b00, 1'b1, 3'b010, 3'b010},
    {2'b10, 1'b0, 3'b100, 3'b100},
    {2'b00, 1'b0, 3'b000, 3'b000}
  };

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pwr", {7'd0, pwr_out}, 10'd0);
    chk("R1 rdata", rdata, 10'd0);

    for (int i = 0; i < 8; i++) begin
      det_pin = VEC[i][8:7];
      settle();
      wr(4'h0, {VEC[i][6], VEC[i][5:3]});
      chk(VEC[i][6] ? ((VEC[i][8:7] != 0) ? "R4 vec" : "R3 vec") : "R2 vec",
          {7'd0, pwr_out}, {7'd0, VEC[i][2:0]});
    end

    // R4: the write that turns gating on is itself blocked
    det_pin = 2'b11; settle();
    wr(4'h0, 4'b0111);
    chk("R2 ungated with detect high", {7'd0, pwr_out}, 10'h007);
    wr(4'h0, 4'b1111);
    chk("R4 gating-on write", {7'd0, pwr_out}, 10'h000);

    // R6 / R5: synchronizer delay, then clear
    det_pin = 2'b00; settle();
    wr(4'h0, 4'b1111);
    chk("R3 seated", {7'd0, pwr_out}, 10'h007);
    @(negedge clk); det_pin = 2'b01;
    repeat (2) @(negedge clk);
    chk("R6 no early clear", {7'd0, pwr_out}, 10'h007);
    @(negedge clk);
    chk("R5 clear on removal", {7'd0, pwr_out}, 10'h000);
    det_pin = 2'b00; settle();
    chk("R5 stays clear", {7'd0, pwr_out}, 10'h000);

    // R8 readback
    wr(4'h0, 4'b1101);
    rd(4'h0);
    chk("R8 cfg read", rdata, 10'h00D);
    wr(4'h0, 4'b0011);
    det_pin = 2'b10; settle();
    rd(4'h0);
    chk("R8 detect read", rdata, 10'h203);
    rd(4'h7);
    chk("R8 other addr", rdata, 10'h000);
    repeat (2) @(negedge clk);
    chk("R8 hold", rdata, 10'h000);

    // R9 foreign write
    wr(4'h5, 4'b0100);
    chk("R9 foreign write", {7'd0, pwr_out}, 10'h003);

    // R7 slot mode
    det_pin = 2'b00;
    @(negedge clk); slot_mode = 1'b1;
    @(negedge clk);
    chk("R7 forced off", {7'd0, pwr_out}, 10'h000);
    wr(4'h0, 4'b0111);
    chk("R7 write ignored", {7'd0, pwr_out}, 10'h000);
    rd(4'h0);
    chk("R7 read", rdata, 10'h000);
    slot_mode = 1'b0;
    wr(4'h0, 4'b0110);
    chk("R2 after slot mode", {7'd0, pwr_out}, 10'h006);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule